// File: doc/BRIEF.md
# Rotating Current-Source Calibration Scheduler

This block sequences the calibration of a bank of current sources that feed the output slots of a converter. There are more physical sources than output slots: 32 slots are served from 33 sources, so one source is always free. A single shared reference can calibrate only one source at a time. Each calibration step picks the source after the free one (modulo 33). It hands that source's output slot to the free source, which is already calibrated. It then walks the selected source through its switch sequence and leaves it as the new free source. Steps follow each other without a gap for as long as the enable is held, so every source is recalibrated once per 33-step cycle and no slot is ever left undriven.

Each source has two switch controls. The reference switch connects the source to the shared reference in diode mode. The position switch selects between the calibrate position and the output position. Entering calibration, the position switch moves first and the reference switch closes one clock later. Leaving calibration, the reference switch opens first and the position switch returns one clock later. A slot is always handed over at least one clock before the position switch of the selected source moves. The time spent with the reference switch closed comes from a period input.

Top module: `cal_rotator`

## Requirements
- R1: While reset is held and after it is released, slot k maps to physical source k (k = 0..31). The free source is 32, all switch controls are low, and `busy` and `cycle_done` are low.
- R2: Successive steps calibrate physical sources in the order (free source + 1) mod 33. After reset this is 0, 1, ..., 32, 0, ...
- R3: At the start of a step, the slot that held the selected source is given the previous free source, and no other slot changes. The new mapping is visible before the selected source's position switch moves.
- R4: At most one bit of `s2_cal` and at most one bit of `s1_close` is high in any cycle.
- R5: For the selected source, `s2_cal` rises one clock before `s1_close` rises. `s1_close` falls while `s2_cal` is still high, and `s2_cal` falls one clock after `s1_close` falls.
- R6: `s1_close` stays high for exactly `period` clocks (a value of 0 gives 1 clock). `period` is sampled in the clock where `s2_cal` first goes high.
- R7: When `s2_cal` of a source falls, that source is not mapped to any slot, and `free_src` names it. It stays unmapped until the next step.
- R8: In every cycle, the 32 slot entries name 32 distinct sources, and none of them has its `s2_cal` bit high.
- R9: `cycle_done` is high for exactly one clock, in the cycle after the step that calibrated source 32 ends. It is never high otherwise.
- R10: When `en` falls, the step in progress completes and then `busy` goes low. While idle, the map, `free_src` and the switch controls hold still. Raising `en` again resumes with the next source in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run continuous calibration steps while high |
| period | input | 16 | Clocks spent with the reference switch closed |
| s1_close | output | 33 | Per source: reference switch closed |
| s2_cal | output | 33 | Per source: position switch in calibrate position |
| slot_map | output | 192 | Slot k's physical source index in bits [6k+5:6k] |
| free_src | output | 6 | Physical source currently driving no slot |
| busy | output | 1 | A calibration step is in progress |
| cycle_done | output | 1 | One-clock pulse after source 32 finishes a step |

## Verification
The hardest situation to reach is the wrap of the rotation. The spare passes from source 32 back to source 0 and the map is far from identity, which is also where `cycle_done` fires. The stimulus gets there by running more than a full cycle of back-to-back steps with the shortest period. A reference model predicts every hand-over from its own copy of the map. An enable drop in the middle of a step and a later resume show that the order carries across an idle gap.

// File: rtl/cal_rotator.sv
module cal_rotator #(
  parameter int N_ACT = 32,
  parameter int PW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [PW-1:0]                 period,
  output logic [N_ACT:0]                s1_close,
  output logic [N_ACT:0]                s2_cal,
  output logic [N_ACT*$clog2(N_ACT+1)-1:0] slot_map,
  output logic [$clog2(N_ACT+1)-1:0]    free_src,
  output logic                          busy,
  output logic                          cycle_done
);
  localparam int N_SRC = N_ACT + 1;
  localparam int IW    = $clog2(N_SRC);
  localparam int SW    = $clog2(N_ACT);
  localparam logic [IW-1:0] LAST = IW'(N_SRC - 1);

  typedef enum logic [2:0] {IDLE, SWAP, GAP, TOCAL, CAL, RELEASE, RETURN} st_t;

  st_t           state;
  logic [IW-1:0] map [N_ACT];
  logic [IW-1:0] spare;
  logic [IW-1:0] tgt;
  logic [SW-1:0] hit_slot;
  logic [PW-1:0] cnt;

  assign tgt      = (spare == LAST) ? '0 : spare + 1'b1;
  assign free_src = (state == IDLE || state == SWAP) ? spare : tgt;
  assign busy     = (state != IDLE);

  always_comb begin
    hit_slot = '0;
    for (int k = 0; k < N_ACT; k++)
      if (map[k] == tgt) hit_slot = k[SW-1:0];
  end

  for (genvar g = 0; g < N_ACT; g++) begin : g_flat
    assign slot_map[g*IW +: IW] = map[g];
  end

  always_comb begin
    s2_cal   = '0;
    s1_close = '0;
    if (state == TOCAL || state == CAL || state == RELEASE) s2_cal[tgt] = 1'b1;
    if (state == CAL) s1_close[tgt] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      spare      <= LAST;
      cnt        <= '0;
      cycle_done <= 1'b0;
      for (int k = 0; k < N_ACT; k++) map[k] <= IW'(k);
    end else begin
      cycle_done <= 1'b0;
      case (state)
        IDLE:    if (en) state <= SWAP;
        SWAP: begin
          map[hit_slot] <= spare;
          state         <= GAP;
        end
        GAP:     state <= TOCAL;
        TOCAL: begin
          cnt   <= (period == '0) ? PW'(1) : period;
          state <= CAL;
        end
        CAL: begin
          if (cnt == PW'(1)) state <= RELEASE;
          else               cnt   <= cnt - 1'b1;
        end
        RELEASE: state <= RETURN;
        RETURN: begin
          spare      <= tgt;
          cycle_done <= (tgt == LAST);
          state      <= en ? SWAP : IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic [N_SRC-1:0] mapped;
  always_comb begin
    mapped = '0;
    for (int k = 0; k < N_ACT; k++) mapped[map[k]] = 1'b1;
  end

  AST_ONE_S2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s2_cal)); // R4
  AST_ONE_S1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s1_close)); // R4
  AST_S2_BEFORE_S1: assert property (@(posedge clk) disable iff (!rst_n) $rose(|s1_close) |-> $past(|s2_cal)); // R5
  AST_S1_OPEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(|s2_cal) |-> !$past(|s1_close)); // R5
  AST_S1_FALL_HOLDS_S2: assert property (@(posedge clk) disable iff (!rst_n) $fell(|s1_close) |-> |s2_cal); // R5
  AST_MAP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) $countones(mapped) == N_ACT); // R8
  AST_CAL_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n) (mapped & s2_cal) == '0); // R8
  AST_RETURN_FREE: assert property (@(posedge clk) disable iff (!rst_n) $fell(|s2_cal) |-> !mapped[free_src]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) cycle_done |=> !cycle_done); // R9
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n) !busy && $past(!busy) |-> $stable(slot_map)); // R10
endmodule

// File: tb/cal_rotator_tb.sv
module cal_rotator_tb;
  localparam int CLK_P = 10;
  localparam int NA = 32;
  localparam int NS = 33;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [15:0] period = 16'd1;
  logic [NS-1:0] s1_close, s2_cal;
  logic [NA*IW-1:0] slot_map;
  logic [IW-1:0] free_src;
  logic busy, cycle_done;

  always #(CLK_P/2) clk = ~clk;

  cal_rotator u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .s1_close(s1_close), .s2_cal(s2_cal), .slot_map(slot_map),
    .free_src(free_src), .busy(busy), .cycle_done(cycle_done)
  );

  typedef struct packed { int tgt; int slot; int spare; int len; } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0;
  int m_map [NA];
  int m_spare;
  int steps_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int slot_of(input int k);
    return int'(slot_map[k*IW +: IW]);
  endfunction

  // monitor / scoreboard
  logic [NS-1:0] p_s1 = '0, p_s2 = '0;
  item_t cur;
  int s1_len = 0;
  bit exp_done = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_s1 <= '0; p_s2 <= '0; exp_done = 1'b0; s1_len = 0;
    end else begin
      // R8 invariant: distinct, and none under calibration
      begin
        logic [NS-1:0] seen;
        bit bad;
        seen = '0; bad = 1'b0;
        for (int k = 0; k < NA; k++) begin
          if (seen[slot_of(k)] || s2_cal[slot_of(k)]) bad = 1'b1;
          seen[slot_of(k)] = 1'b1;
        end
        if (bad) chk(1'b0, "R8 slot map distinct and not in calibration", 1, 0);
      end
      if ($countones(s2_cal) > 1 || $countones(s1_close) > 1)
        chk(1'b0, "R4 single source in calibration", $countones(s2_cal), 1);
      if (exp_done) begin
        chk(cycle_done == 1'b1, "R9 cycle_done pulse", cycle_done, 1);
        exp_done = 1'b0;
      end else if (cycle_done) chk(1'b0, "R9 unexpected cycle_done", 1, 0);
      if (p_s2 == '0 && s2_cal != '0) begin
        steps_seen++;
        if (q.size() == 0) begin
          chk(1'b0, "R2 step with no expected item", idx_of(s2_cal), -1);
          cur = '{tgt: -1, slot: 0, spare: 0, len: 0};
        end else begin
          cur = q.pop_front();
          chk(idx_of(s2_cal) == cur.tgt, "R2 calibration order", idx_of(s2_cal), cur.tgt);
          chk(slot_of(cur.slot) == cur.spare, "R3 slot handed to spare", slot_of(cur.slot), cur.spare);
          chk(s1_close == '0, "R5 S2 moves before S1 closes", idx_of(s1_close), -1);
        end
        s1_len = 0;
      end
      if (s1_close != '0) begin
        s1_len++;
        if (s1_close != s2_cal) chk(1'b0, "R5 S1 closed without S2", idx_of(s1_close), idx_of(s2_cal));
      end
      if (p_s1 != '0 && s1_close == '0) begin
        chk(s1_len == cur.len, "R6 calibration length", s1_len, cur.len);
        chk(s2_cal == p_s1, "R5 S2 held after S1 opens", idx_of(s2_cal), idx_of(p_s1));
      end
      if (p_s2 != '0 && s2_cal == '0) begin
        chk(p_s1 == '0, "R5 S1 open one clock before S2 returns", idx_of(p_s1), -1);
        chk(int'(free_src) == cur.tgt, "R7 returned source is free", free_src, cur.tgt);
        begin
          bit m;
          m = 1'b0;
          for (int k = 0; k < NA; k++) if (slot_of(k) == cur.tgt) m = 1'b1;
          chk(!m, "R7 returned source unmapped", m, 0);
        end
        exp_done = (cur.tgt == NS - 1);
      end
      p_s1 <= s1_close;
      p_s2 <= s2_cal;
    end
  end

  task automatic run_steps(input int n, input int p);
    int goal;
    period = 16'(p);
    for (int i = 0; i < n; i++) begin
      item_t it;
      int t, sl;
      t = (m_spare + 1) % NS;
      sl = -1;
      for (int k = 0; k < NA; k++) if (m_map[k] == t) sl = k;
      it = '{tgt: t, slot: sl, spare: m_spare, len: (p == 0) ? 1 : p};
      q.push_back(it);
      m_map[sl] = m_spare;
      m_spare = t;
    end
    goal = steps_seen + n;
    en = 1'b1;
    while (steps_seen < goal) @(negedge clk);
    en = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(q.size() == 0, "R10 all expected steps ran", q.size(), 0);
    chk(int'(free_src) == m_spare, "R10 free source after stop", free_src, m_spare);
    begin
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < NA; k++) if (slot_of(k) != m_map[k]) ok = 1'b0;
      chk(ok, "R3 full map matches model", ok, 1);
    end
  endtask

  task automatic idle_hold(input int cyc);
    logic [NA*IW-1:0] snap;
    logic [IW-1:0] fs;
    bit ok;
    snap = slot_map; fs = free_src; ok = 1'b1;
    period = 16'd9;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (slot_map != snap || free_src != fs || busy || s2_cal != '0 || s1_close != '0) ok = 1'b0;
    end
    chk(ok, "R10 idle keeps state", ok, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NA; k++) m_map[k] = k;
    m_spare = NS - 1;
    repeat (3) @(negedge clk);
    begin
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < NA; k++) if (slot_of(k) != k) ok = 1'b0;
      chk(ok, "R1 identity map in reset", ok, 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(free_src) == NS - 1, "R1 free source after reset", free_src, NS - 1);
    chk(s1_close == '0 && s2_cal == '0, "R1 switches idle", idx_of(s2_cal), -1);
    chk(!busy && !cycle_done, "R1 status low", {busy, cycle_done}, 0);
    run_steps(3, 3);
    idle_hold(20);
    run_steps(35, 0);
    idle_hold(10);
    run_steps(2, 7);
    run_steps(1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule